// File: doc/BRIEF.md
# Nibble Serial Link Master

This block is a hardware master for a three-wire link to a small serial clock chip. The link has a chip enable, a serial clock and a single bidirectional data line. The host hands the block a request carrying a 4-bit register address, a read/write flag and, for writes, a 4-bit value. The block then serialises one fixed 16-bit frame on the link. For a write, every bit of the frame is driven. For a read, the block drives the first half of the frame, releases the data line and collects the chip's answer.

The frame is nibble oriented. A 4-bit control header marks the access direction and whether an address or a data field follows. The address is sent next. A write follows it with a second header and the data nibble. A read instead turns the line around, throws away four received bits and keeps the next four bits as the result.

Chip enable is owned by an external sequencer, so one enable window can frame several accesses. The block only forwards the enable to the link. It refuses to start a frame while the enable is low. The data line is exposed as a value plus a separate output enable, so the pad can be built at the chip top level.

Top module: `nlm_master`

## Requirements
- R1: After reset, `req_ready` is 1 and `link_sclk`, `link_oe`, `done`, `err` and `rd_data` are all 0.
- R2: A request seen with `req_ready` high while `ce_in` is low starts no frame. `err` pulses for exactly one cycle and `req_ready` stays 1. `link_sclk` and `link_oe` stay 0, and `rd_data` keeps its value.
- R3: `link_ce` equals `ce_in` delayed by one clock.
- R4: Every frame has exactly 16 bit periods, each lasting 2*HALF_CLKS clocks. In each period `link_sclk` is low for the first HALF_CLKS clocks and high for the last HALF_CLKS clocks.
- R5: A read drives bits 0..7 with `link_oe` high. Bits 0..3 are the header 1,1,1,0 (unused, read flag = 1, address-phase flag, data-phase flag). Bits 4..7 are the address, most significant bit first.
- R6: On a read, `link_oe` is low for bits 8..15. Bits 8..11 received on `link_din` are discarded. Bits 12..15 form `rd_data`, with bit 12 as the most significant.
- R7: A write drives all 16 bits with `link_oe` high, in this order: 1,0,1,0, then the address MSB first, then 1,0,0,1, then the write data MSB first.
- R8: `link_dout` and `link_oe` change only on the clock that ends a bit, while `link_sclk` goes low, and hold steady while `link_sclk` is high. `link_din` is sampled on the last clock of the high phase.
- R9: `req_ready` is low from the clock after a request is accepted until the frame ends. Requests made while it is low are not taken and produce no extra frame.
- R10: When a frame ends, `done` pulses for one cycle and `req_ready` returns high in the same cycle. `rd_data` changes only in that cycle and only for a read; a write leaves it unchanged.
- R11: `link_oe` rises only on the clock after a request is accepted with `ce_in` high. It is 1 for the first bit of every access and 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_in | input | 1 | Chip enable from the external sequencer |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write value |
| rd_data | output | 4 | Result of the last read |
| done | output | 1 | One-cycle pulse when a frame completes |
| err | output | 1 | One-cycle pulse when a request is refused for low enable |
| link_ce | output | 1 | Chip enable to the link |
| link_sclk | output | 1 | Serial clock to the link |
| link_dout | output | 1 | Data value driven onto the line |
| link_oe | output | 1 | Data line output enable |
| link_din | input | 1 | Data value read from the line |

## Verification
The assertions assume that the sequencer holds `ce_in` high for the whole of any frame it started. They also assume that the chip model changes `link_din` only after a rising serial clock edge, well before the sample point. The bench enforces both: it changes `ce_in` only while the block is idle, and it derives the chip's answer from the count of rising serial clock edges, moving `link_din` half a system clock after each edge. The request fields are read only in the accepting cycle. The bench nevertheless holds them steady until acceptance, and a request it holds during a frame is dropped before the frame ends.

// File: rtl/nlm_pkg.sv
package nlm_pkg;

  localparam int NIB_W      = 4;
  localparam int FRAME_BITS = 4 * NIB_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int HALF_BITS  = FRAME_BITS / 2;

  // Control headers, first bit sent is the MSB
  localparam logic [NIB_W-1:0] HDR_READ    = 4'b1110;
  localparam logic [NIB_W-1:0] HDR_WR_ADDR = 4'b1010;
  localparam logic [NIB_W-1:0] HDR_WR_DATA = 4'b1001;

  typedef struct packed {
    logic             wr;
    logic [NIB_W-1:0] addr;
    logic [NIB_W-1:0] wdata;
  } acc_t;

endpackage

// File: rtl/nlm_bit_timer.sv
module nlm_bit_timer #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_now,
  output logic bit_end
);
  localparam int PERIOD = 2 * HALF_CLKS;
  localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= '0;
    end else if (phase == CW'(PERIOD - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // rise_now: last low clock of a bit; bit_end: last high clock of a bit
  assign rise_now = run && (phase == CW'(HALF_CLKS - 1));
  assign bit_end  = run && (phase == CW'(PERIOD - 1));

endmodule

// File: rtl/nlm_frame_map.sv
module nlm_frame_map
  import nlm_pkg::*;
(
  input  acc_t             acc,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o,
  output logic             oe_o
);
  logic [FRAME_BITS-1:0] rd_vec;
  logic [FRAME_BITS-1:0] rd_oe;
  logic [FRAME_BITS-1:0] wr_vec;
  logic [IDX_W-1:0]      pos;

  always_comb begin
    rd_vec = {HDR_READ, acc.addr, {HALF_BITS{1'b0}}};
    rd_oe  = {{HALF_BITS{1'b1}}, {HALF_BITS{1'b0}}};
    wr_vec = {HDR_WR_ADDR, acc.addr, HDR_WR_DATA, acc.wdata};
    pos    = IDX_W'(FRAME_BITS - 1) - idx;
    bit_o  = acc.wr ? wr_vec[pos] : rd_vec[pos];
    oe_o   = acc.wr ? 1'b1 : rd_oe[pos];
  end

endmodule

// File: rtl/nlm_rx_shift.sv
module nlm_rx_shift #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  // Every received bit passes through; only the last W remain.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[W-2:0], din};
    end
  end

endmodule

// File: rtl/nlm_master.sv
module nlm_master
  import nlm_pkg::*;
#(
  parameter int HALF_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_in,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [NIB_W-1:0] req_addr,
  input  logic [NIB_W-1:0] req_wdata,
  output logic [NIB_W-1:0] rd_data,
  output logic             done,
  output logic             err,
  output logic             link_ce,
  output logic             link_sclk,
  output logic             link_dout,
  output logic             link_oe,
  input  logic             link_din
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic             busy;
  logic [IDX_W-1:0] idx;
  acc_t             acc_q;
  acc_t             map_acc;
  logic [IDX_W-1:0] map_idx;
  logic             map_bit;
  logic             map_oe;
  logic             rise_now;
  logic             bit_end;
  logic [NIB_W-1:0] rx_q;
  logic             take;

  assign take = req_valid && req_ready;

  nlm_bit_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .rise_now (rise_now),
    .bit_end  (bit_end)
  );

  // Idle: look at bit 0 of the incoming request; busy: next bit of the latched one
  always_comb begin
    map_acc = busy ? acc_q : acc_t'{wr: req_write, addr: req_addr, wdata: req_wdata};
    map_idx = busy ? idx + 1'b1 : '0;
  end

  nlm_frame_map u_map (
    .acc   (map_acc),
    .idx   (map_idx),
    .bit_o (map_bit),
    .oe_o  (map_oe)
  );

  nlm_rx_shift #(.W(NIB_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .shift_en (busy && bit_end && !link_oe),
    .din      (link_din),
    .q        (rx_q)
  );

  always_ff @(posedge clk) begin
    link_ce <= ce_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      acc_q     <= '0;
      req_ready <= 1'b1;
      link_sclk <= 1'b0;
      link_dout <= 1'b0;
      link_oe   <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (take) begin
          if (!ce_in) begin
            err <= 1'b1;
          end else begin
            busy      <= 1'b1;
            req_ready <= 1'b0;
            idx       <= '0;
            acc_q     <= map_acc;
            link_sclk <= 1'b0;
            link_dout <= map_bit;
            link_oe   <= map_oe;
          end
        end
      end else begin
        if (rise_now) begin
          link_sclk <= 1'b1;
        end
        if (bit_end) begin
          link_sclk <= 1'b0;
          if (idx == LAST_IDX) begin
            busy      <= 1'b0;
            req_ready <= 1'b1;
            done      <= 1'b1;
            link_oe   <= 1'b0;
            link_dout <= 1'b0;
            if (!acc_q.wr) begin
              rd_data <= {rx_q[NIB_W-2:0], link_din};
            end
          end else begin
            idx       <= idx + 1'b1;
            link_dout <= map_bit;
            link_oe   <= map_oe;
          end
        end
      end
    end
  end

endmodule

// File: rtl/nlm_master_chk.sv
module nlm_master_chk #(
  parameter int HALF_CLKS = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       ce_in,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] rd_data,
  input logic       done,
  input logic       err,
  input logic       link_ce,
  input logic       link_sclk,
  input logic       link_dout,
  input logic       link_oe
);
  localparam int HW = $clog2(HALF_CLKS + 2);

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
    end else if (link_sclk) begin
      hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
    end
  end

  assert_err_cause_R2: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req_valid && req_ready && !ce_in));

  assert_err_keeps_idle_R2: assert property (@(posedge clk) disable iff (rst)
    err |-> (req_ready && !link_oe && !link_sclk));

  assert_ce_follows_R3: assert property (@(posedge clk) disable iff (rst)
    link_ce == $past(ce_in));

  assert_high_phase_len_R4: assert property (@(posedge clk) disable iff (rst)
    hi_run <= HW'(HALF_CLKS));

  assert_hold_while_high_R8: assert property (@(posedge clk) disable iff (rst)
    (link_sclk && $past(link_sclk)) |-> ($stable(link_dout) && $stable(link_oe)));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    link_sclk |-> !req_ready);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ready_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  assert_rd_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rd_data));

  assert_idle_release_R11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !link_oe);

  assert_oe_start_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(link_oe) |-> $past(req_valid && req_ready && ce_in));

endmodule

bind nlm_master nlm_master_chk #(.HALF_CLKS(HALF_CLKS)) u_nlm_chk (
  .clk       (clk),
  .rst       (rst),
  .ce_in     (ce_in),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_data   (rd_data),
  .done      (done),
  .err       (err),
  .link_ce   (link_ce),
  .link_sclk (link_sclk),
  .link_dout (link_dout),
  .link_oe   (link_oe)
);

// File: tb/test_nlm_master.sv
`timescale 1ns/1ps
module test_nlm_master;
  localparam int HALF = 3;
  localparam int BITS = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       ce_in;
  logic       req_valid;
  logic       req_ready;
  logic       req_write;
  logic [3:0] req_addr;
  logic [3:0] req_wdata;
  logic [3:0] rd_data;
  logic       done;
  logic       err;
  logic       link_ce;
  logic       link_sclk;
  logic       link_dout;
  logic       link_oe;
  logic       link_din;

  always #2.5 clk = ~clk;

  nlm_master #(.HALF_CLKS(HALF)) i_nlm_master (
    .clk(clk), .rst(rst), .ce_in(ce_in), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .err(err),
    .link_ce(link_ce), .link_sclk(link_sclk), .link_dout(link_dout),
    .link_oe(link_oe), .link_din(link_din)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] bits;
    logic [15:0] oe;
    logic [3:0]  rd;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          fails  = 0;
  int          k = 0;
  int          since_rise = 0;
  logic        prev_sclk = 1'b0;
  logic [15:0] obs_b = '0;
  logic [15:0] obs_oe = '0;
  logic [7:0]  resp = '0;
  logic [3:0]  last_rd = '0;

  // chip model: answer bits for frame bits 8..15, indexed by rising edges seen
  assign link_din = (k >= 9 && k <= 16) ? resp[16-k] : 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: records the frame at each rising serial edge, scores it at done
  always @(negedge clk) begin
    if (!rst) begin
      since_rise++;
      if (link_sclk && !prev_sclk) begin
        if (k > 0) check(since_rise == 2*HALF, "R4", "bit period", since_rise, 2*HALF);
        if (k < BITS) begin
          obs_b[BITS-1-k]  = link_dout;
          obs_oe[BITS-1-k] = link_oe;
        end
        k++;
        since_rise = 0;
      end
      prev_sclk = link_sclk;
      if (done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R9", "done without request", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(k == BITS, "R4", "rising edges in frame", k, BITS);
          check(obs_oe == e.oe, e.wr ? "R7" : "R6", "oe pattern", obs_oe, e.oe);
          check((obs_b & e.oe) == (e.bits & e.oe), e.wr ? "R7" : "R5",
                "driven bits", obs_b & e.oe, e.bits & e.oe);
          check(rd_data == e.rd, e.wr ? "R10" : "R6", "rd_data", rd_data, e.rd);
          check(req_ready == 1'b1, "R10", "ready with done", req_ready, 1);
        end
        k = 0;
      end
    end
  end

  task automatic access(input logic wr, input logic [3:0] addr,
                        input logic [3:0] wd, input logic [7:0] answer);
    exp_t e;
    e.wr = wr;
    if (wr) begin
      e.bits = {4'b1010, addr, 4'b1001, wd};
      e.oe   = 16'hFFFF;
      e.rd   = last_rd;
    end else begin
      e.bits = {4'b1110, addr, 8'h00};
      e.oe   = 16'hFF00;
      e.rd   = answer[3:0];
      last_rd = answer[3:0];
    end
    sb_q.push_back(e);
    resp      = answer;
    req_write = wr;
    req_addr  = addr;
    req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~addr;
    req_wdata = ~wd;
    check(req_ready == 1'b0, "R9", "ready after accept", req_ready, 0);
    check(link_oe == 1'b1, "R11", "oe on first bit", link_oe, 1);
    // a request held mid-frame must not be taken
    repeat (5) @(negedge clk);
    req_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic refused(input logic [3:0] rd_exp);
    ce_in     = 1'b0;
    @(negedge clk);
    req_write = 1'b0;
    req_addr  = 4'h5;
    req_valid = 1'b1;
    @(negedge clk);
    check(err == 1'b1, "R2", "err pulse", err, 1);
    check(req_ready == 1'b1, "R2", "ready kept", req_ready, 1);
    req_valid = 1'b0;
    @(negedge clk);
    check(err == 1'b0, "R2", "err one cycle", err, 0);
    repeat (20) begin
      @(negedge clk);
      if (link_sclk || link_oe) check(1'b0, "R2", "link activity", 1, 0);
    end
    check(rd_data == rd_exp, "R2", "rd_data kept", rd_data, rd_exp);
    check(link_ce == 1'b0, "R3", "ce low forwarded", link_ce, 0);
    ce_in = 1'b1;
    @(negedge clk);
    check(link_ce == 1'b1, "R3", "ce high forwarded", link_ce, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R9 watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; ce_in = 1'b0; req_valid = 1'b0;
    req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    check(link_sclk == 1'b0 && link_oe == 1'b0, "R1", "link idle",
          {link_sclk, link_oe}, 0);
    check(done == 1'b0 && err == 1'b0, "R1", "pulses idle", {done, err}, 0);
    check(rd_data == 4'h0, "R1", "rd_data", rd_data, 0);
    ce_in = 1'b1;
    @(negedge clk);
    check(link_ce == 1'b1, "R3", "ce forwarded", link_ce, 1);

    refused(4'h0);
    access(1'b0, 4'hD, 4'h0, 8'h5A);  // read, junk 5, value A
    access(1'b1, 4'h3, 4'h9, 8'hFF);  // write
    access(1'b0, 4'h0, 4'h0, 8'hF0);  // all-ones in discarded bits
    access(1'b0, 4'hF, 4'h0, 8'h0F);  // all-ones value
    access(1'b1, 4'hF, 4'h0, 8'h00);  // write must leave rd_data at F
    access(1'b0, 4'h6, 4'h0, 8'hC3);
    refused(4'h3);

    check(sb_q.size() == 0, "R10", "outstanding frames", sb_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule